// File: doc/BRIEF.md
# External Memory Chip-Select and Byte-Lane Mapper

This block sits between an internal memory request port and an external static-memory bus. Each request carries a byte address, a read/write flag, four byte enables and a valid strobe. The block decodes three address bits into one of eight active-low chip selects. It presents the low 26 address bits on the external address bus. It drives the shared active-low read and write strobes and a set of four active-low byte-lane lines. Every chip select owns a 64-Mbyte window. A device smaller than that simply repeats inside its window, because the block passes the low address bits through and checks no range.

Each chip select has a small configuration register holding two settings. The first is its bus width (8, 16 or 32 bits). The second is, for the wider widths, whether the lane lines act as byte selects that follow the byte enables on every access, or as per-lane write strobes. In that second case all lanes are asserted on reads. Every output is registered, so a request sampled at one clock edge appears on the pins just after that edge, for one cycle.

Top module: `ext_mem_mapper`

## Requirements
- R1: While reset is asserted (synchronous, active low), all chip selects, the read strobe, the write strobe and all lane lines are high, the address bus is zero, and every configuration register reads back 0 (8-bit width, byte-select access).
- R2: A valid request asserts exactly the chip select numbered by request address bits [28:26], low, in the next cycle. A cycle without a valid request leaves all chip selects, both strobes and all lane lines high and the address bus at zero.
- R3: The address bus carries request address bits [25:0], except that bit 0 is forced to 0 for 16-bit width and bits [1:0] are forced to 0 for 32-bit width. Request bits [31:29] have no effect, so addresses differing only there give identical outputs.
- R4: A valid read drives the read strobe low and the write strobe high. A valid write drives the write strobe low and the read strobe high. The two are never low together.
- R5: For 8-bit width (width code 00), and for the reserved code 11, which behaves as 8-bit: lane 0 is low on every access and lanes 1 to 3 are high, whatever the byte enables and the access type.
- R6: For byte-select access (type bit 0) at 16-bit width (code 01) or 32-bit width (code 10): on both reads and writes, each lane within the width is low exactly when its byte enable is 1. Lanes beyond the width (lanes 2 and 3 at 16-bit) are high.
- R7: For byte-write access (type bit 1) at 16- or 32-bit width: on writes, each lane within the width is low exactly when its byte enable is 1. On reads, all lanes within the width are low. Lanes beyond the width are high.
- R8: A configuration write stores cfg_wdata, with bit 2 the access type and bits [1:0] the width code, into the register of the chip select named by cfg_sel. cfg_rdata returns the register named by cfg_sel. A write to one chip select leaves the other seven unchanged.
- R9: Outputs reflect the request sampled at the previous clock edge. A configuration write made at the same edge as a request does not affect that request; it affects only requests sampled at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Internal byte address; [28:26] select chip |
| req_be | input | 4 | Byte enables, bit i for lane i |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Chip select addressed for write and read-back |
| cfg_wdata | input | 3 | {access type, width code} |
| cfg_rdata | output | 3 | Setting of chip select cfg_sel |
| ncs_o | output | 8 | Active-low chip selects |
| ext_addr | output | 26 | External address bus |
| nrd_o | output | 1 | Active-low shared read strobe |
| nwe_o | output | 1 | Active-low shared write strobe |
| nlane_o | output | 4 | Active-low byte selects or per-lane write strobes |

## Verification
The bench steers requests across all eight windows with every width code, including the reserved one, and both access types. A decoder that mixed up the two access types would show it only on reads, where byte-write mode must assert every lane while byte-select mode follows the enables. The bench therefore sends sparse byte-enable patterns on reads. Narrow-width requests use enables that include upper lanes, which a design that failed to mask by width would leak onto lanes 1 to 3. Addresses with odd low bits and set top bits catch a wrong address mask and any upper-bit leakage into the window, and a request issued on the same edge as a reconfiguration of its own chip select catches a design that uses the new setting one cycle early.

// File: rtl/mmap_pkg.sv
// Package: shared types for the external memory mapper.
// Assumes a 32-bit maximum external data bus (four byte lanes).
package mmap_pkg;

    // Width code of one chip select; the reserved code behaves as 8-bit.
    typedef enum logic [1:0] {
        BW8   = 2'b00,
        BW16  = 2'b01,
        BW32  = 2'b10,
        BWRSV = 2'b11
    } bus_width_e;

    // Per-chip-select setting: bit 2 access type (1 = byte write), bits 1:0 width.
    typedef struct packed {
        logic       byte_wr;
        bus_width_e width;
    } cs_cfg_t;

    localparam int CFG_W = $bits(cs_cfg_t);

    // Number of byte lanes a width occupies.
    function automatic int lanes_used(bus_width_e w);
        case (w)
            BW16:    return 2;
            BW32:    return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/mmap_cfg_regs.sv
// Module: per-chip-select configuration registers.
// Holds one cs_cfg_t per chip select, written by a simple strobe and read
// back combinationally. A second read port serves the request path.
// Assumes synchronous active-low reset to 8-bit, byte-select settings.
module mmap_cfg_regs
    import mmap_pkg::*;
#(
    parameter  int N_CS = 8,
    localparam int CS_W = $clog2(N_CS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CS_W-1:0] wr_sel,
    input  cs_cfg_t         wr_data,
    output cs_cfg_t         rd_data,
    input  logic [CS_W-1:0] req_sel,
    output cs_cfg_t         req_cfg
);

    cs_cfg_t cfg_q [N_CS];

    for (genvar g = 0; g < N_CS; g++) begin : g_reg
        // Store a new setting when this chip select is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (wr_en && (wr_sel == CS_W'(g)))
                cfg_q[g] <= wr_data;
        end
    end

    // Read-back and request-side lookup.
    always_comb begin
        rd_data = cfg_q[wr_sel];
        req_cfg = cfg_q[req_sel];
    end

endmodule

// File: rtl/mmap_lane_gen.sv
// Module: byte-lane strobe generator (combinational, active high).
// Decides which lanes are asserted for one access from the width, the
// access type, the direction and the byte enables. 8-bit (and reserved)
// width uses lane 0 only; lanes outside the width stay deasserted.
module mmap_lane_gen
    import mmap_pkg::*;
#(
    parameter int LANES = 4
) (
    input  cs_cfg_t          cfg,
    input  logic             is_write,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] lane_on
);

    logic narrow;
    logic all_on_read;

    // Mode flags shared by every lane.
    always_comb begin
        narrow      = (lanes_used(cfg.width) == 1);
        all_on_read = cfg.byte_wr && !is_write;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // One lane: inside the width, then by mode.
        always_comb begin
            if (i >= lanes_used(cfg.width))
                lane_on[i] = 1'b0;
            else if (narrow || all_on_read)
                lane_on[i] = 1'b1;
            else
                lane_on[i] = be[i];
        end
    end

endmodule

// File: rtl/ext_mem_mapper.sv
// Module: external memory chip-select and byte-lane mapper (top).
// Turns a one-cycle internal request into registered external signals:
// active-low chip select from address bits above the window, masked
// window address, shared read/write strobes and active-low lane lines.
// Assumes the requester holds nothing beyond one cycle; no timing phases.
module ext_mem_mapper
    import mmap_pkg::*;
#(
    parameter  int N_CS   = 8,
    parameter  int WIN_AW = 26,
    parameter  int REQ_AW = 32,
    parameter  int LANES  = 4,
    localparam int CS_W   = $clog2(N_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic              cfg_wr_en,
    input  logic [CS_W-1:0]   cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [N_CS-1:0]   ncs_o,
    output logic [WIN_AW-1:0] ext_addr,
    output logic              nrd_o,
    output logic              nwe_o,
    output logic [LANES-1:0]  nlane_o
);

    logic [CS_W-1:0]   cs_idx;
    cs_cfg_t           sel_cfg;
    cs_cfg_t           rd_cfg;
    logic [LANES-1:0]  lane_on;
    logic [WIN_AW-1:0] addr_next;
    logic              unused_hi;

    // Chip number from the bits just above the window; upper bits alias.
    always_comb begin
        cs_idx    = req_addr[WIN_AW +: CS_W];
        unused_hi = ^req_addr[REQ_AW-1:WIN_AW+CS_W];
    end

    mmap_cfg_regs #(.N_CS(N_CS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_sel),
        .wr_data (cs_cfg_t'(cfg_wdata)),
        .rd_data (rd_cfg),
        .req_sel (cs_idx),
        .req_cfg (sel_cfg)
    );

    // Present the read-back value as plain bits.
    always_comb cfg_rdata = rd_cfg;

    mmap_lane_gen #(.LANES(LANES)) u_lane (
        .cfg      (sel_cfg),
        .is_write (req_write),
        .be       (req_be),
        .lane_on  (lane_on)
    );

    // Clear the address bits below the bus width of the selected device.
    always_comb begin
        addr_next = req_addr[WIN_AW-1:0];
        case (sel_cfg.width)
            BW16:    addr_next[0]   = 1'b0;
            BW32:    addr_next[1:0] = 2'b00;
            default: ;
        endcase
    end

    // Register every external signal; idle cycles park everything inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            ncs_o    <= '1;
            ext_addr <= '0;
            nrd_o    <= 1'b1;
            nwe_o    <= 1'b1;
            nlane_o  <= '1;
        end else begin
            ncs_o    <= ~(N_CS'(1) << cs_idx);
            ext_addr <= addr_next;
            nrd_o    <= req_write;
            nwe_o    <= !req_write;
            nlane_o  <= ~lane_on;
        end
    end

endmodule

// File: rtl/mmap_checker.sv
// Module: property checker for ext_mem_mapper, attached by bind.
// Observes ports only; all properties are disabled during reset.
module mmap_checker #(
    parameter  int N_CS   = 8,
    parameter  int WIN_AW = 26,
    parameter  int REQ_AW = 32,
    parameter  int LANES  = 4,
    localparam int CS_W   = $clog2(N_CS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [REQ_AW-1:0] req_addr,
    input logic [N_CS-1:0]   ncs_o,
    input logic [WIN_AW-1:0] ext_addr,
    input logic              nrd_o,
    input logic              nwe_o,
    input logic [LANES-1:0]  nlane_o
);

    a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ncs_o));

    a_r2_right_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) |-> !ncs_o[$past(req_addr[WIN_AW +: CS_W])]);

    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(req_valid) |-> (&ncs_o) && nrd_o && nwe_o && (&nlane_o)
                                               && (ext_addr == '0));

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        nrd_o || nwe_o);

    a_r4_direction: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) |-> (nwe_o == !$past(req_write))
                                              && (nrd_o == $past(req_write)));

    a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) |-> ext_addr[WIN_AW-1:2] == $past(req_addr[WIN_AW-1:2]));

endmodule

bind ext_mem_mapper mmap_checker #(
    .N_CS(N_CS), .WIN_AW(WIN_AW), .REQ_AW(REQ_AW), .LANES(LANES)
) u_mmap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .ncs_o     (ncs_o),
    .ext_addr  (ext_addr),
    .nrd_o     (nrd_o),
    .nwe_o     (nwe_o),
    .nlane_o   (nlane_o)
);

// File: tb/test_ext_mem_mapper.sv
// Bench: behavioural per-cycle reference model compared after every edge.
module test_ext_mem_mapper;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_addr;
    logic [3:0]  req_be;
    logic        cfg_wr_en;
    logic [2:0]  cfg_sel;
    logic [2:0]  cfg_wdata;
    logic [2:0]  cfg_rdata;
    logic [7:0]  ncs_o;
    logic [25:0] ext_addr;
    logic        nrd_o, nwe_o;
    logic [3:0]  nlane_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int m_w  [8];
    int m_bw [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_mem_mapper i_ext_mem_mapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .cfg_wr_en(cfg_wr_en),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ncs_o(ncs_o), .ext_addr(ext_addr), .nrd_o(nrd_o), .nwe_o(nwe_o),
        .nlane_o(nlane_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One cycle: drive at the falling edge, predict, compare after the rising edge.
    task automatic cycle(bit v, bit w, logic [31:0] a, logic [3:0] be,
                         bit cw, logic [2:0] cs_s, logic [2:0] cd, string note);
        logic [7:0]  e_ncs;
        logic [25:0] e_addr;
        logic        e_nrd, e_nwe;
        logic [3:0]  e_lane;
        string       lt;
        req_valid = v; req_write = w; req_addr = a; req_be = be;
        cfg_wr_en = cw; cfg_sel = cs_s; cfg_wdata = cd;
        e_ncs = 8'hFF; e_addr = '0; e_nrd = 1; e_nwe = 1; e_lane = 4'hF; lt = "R2";
        if (v) begin
            int cs = int'(a[28:26]);
            int nb = (m_w[cs] == 1) ? 2 : (m_w[cs] == 2) ? 4 : 1;
            e_ncs  = ~(8'd1 << cs);
            e_addr = a[25:0] & ~26'(nb - 1);
            e_nrd  = w;
            e_nwe  = !w;
            for (int i = 0; i < 4; i++) begin
                bit on;
                if (i >= nb)                  on = 0;
                else if (nb == 1)             on = 1;
                else if (m_bw[cs] != 0 && !w) on = 1;
                else                          on = be[i];
                e_lane[i] = !on;
            end
            lt = (nb == 1) ? "R5" : (m_bw[cs] != 0) ? "R7" : "R6";
        end
        if (cw && rst_n) begin
            m_w[cs_s]  = int'(cd[1:0]);
            m_bw[cs_s] = int'(cd[2]);
        end
        @(posedge clk);
        @(negedge clk);
        chk({"R2 ", note}, "ncs", 32'(ncs_o), 32'(e_ncs));
        chk({"R3 ", note}, "addr", 32'(ext_addr), 32'(e_addr));
        chk({"R4 ", note}, "nrd/nwe", {30'd0, nrd_o, nwe_o}, {30'd0, e_nrd, e_nwe});
        chk({lt, " ", note}, "lanes", 32'(nlane_o), 32'(e_lane));
        chk({"R8 ", note}, "cfg_rdata", 32'(cfg_rdata), {29'd0, 1'(m_bw[cs_s]), 2'(m_w[cs_s])});
    endtask

    task automatic idle(string note);
        cycle(0, 0, '0, '0, 0, '0, '0, note);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_w[i] = 0; m_bw[i] = 0; end
        rst_n = 0; req_valid = 1; req_write = 0; req_addr = 32'h1234_5677;
        req_be = 4'hF; cfg_wr_en = 1; cfg_sel = 3'd2; cfg_wdata = 3'b110;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports, and a config write in reset is dropped.
        chk("R1", "ncs", 32'(ncs_o), 32'hFF);
        chk("R1", "addr", 32'(ext_addr), 0);
        chk("R1", "strobes", {29'd0, nrd_o, nwe_o, 1'b0}, {29'd0, 3'b110});
        chk("R1", "lanes", 32'(nlane_o), 32'hF);
        cfg_wr_en = 0;
        for (int s = 0; s < 8; s++) begin
            cfg_sel = 3'(s); #1;
            chk("R1", "cfg reset", 32'(cfg_rdata), 0);
        end
        rst_n = 1;
        idle("post-reset idle");

        // R5: default 8-bit, enables on upper lanes must not leak.
        cycle(1, 0, 32'h0C00_0003, 4'b1110, 0, 0, 0, "8-bit read");
        cycle(1, 1, 32'h0C00_0005, 4'b0110, 0, 0, 0, "8-bit write");
        // R8: program several chip selects.
        cycle(0, 0, 0, 0, 1, 3'd1, 3'b001, "cfg cs1 16 bsel");
        cycle(0, 0, 0, 0, 1, 3'd2, 3'b010, "cfg cs2 32 bsel");
        cycle(0, 0, 0, 0, 1, 3'd4, 3'b110, "cfg cs4 32 bwr");
        cycle(0, 0, 0, 0, 1, 3'd5, 3'b101, "cfg cs5 16 bwr");
        cycle(0, 0, 0, 0, 1, 3'd6, 3'b111, "cfg cs6 reserved");
        // R8 independence: others untouched.
        for (int s = 0; s < 8; s++) cycle(0, 0, 0, 0, 0, 3'(s), 0, "R8 readback");
        // R6: byte select, sparse enables on reads and writes.
        cycle(1, 0, 32'h0400_0003, 4'b0110, 0, 0, 0, "16 bsel read");
        cycle(1, 1, 32'h0800_0007, 4'b1010, 0, 0, 0, "32 bsel write");
        cycle(1, 0, 32'h0800_0002, 4'b0001, 0, 0, 0, "32 bsel read");
        // R7: byte write, reads assert all lanes within width.
        cycle(1, 0, 32'h1000_0001, 4'b0010, 0, 0, 0, "32 bwr read");
        cycle(1, 1, 32'h1000_0006, 4'b0100, 0, 0, 0, "32 bwr write");
        cycle(1, 0, 32'h1400_0003, 4'b0000, 0, 0, 0, "16 bwr read");
        cycle(1, 1, 32'h1400_0001, 4'b1110, 0, 0, 0, "16 bwr write");
        cycle(1, 1, 32'h1BFF_FFFF, 4'b1110, 0, 0, 0, "R5 reserved code");
        // R3: top bits alias, same result as without them.
        cycle(1, 1, 32'hE800_0007, 4'b1010, 0, 0, 0, "R3 alias high bits");
        cycle(1, 0, 32'h0BFF_FFFF, 4'b1111, 0, 0, 0, "R3 top of window");
        // R9: reconfigure cs1 in the same cycle as a request to it.
        cycle(1, 0, 32'h0400_0001, 4'b0100, 1, 3'd1, 3'b110, "R9 same-edge cfg");
        cycle(1, 0, 32'h0400_0001, 4'b0100, 0, 3'd1, 0, "R9 next request");
        // R2: back-to-back requests to every window.
        for (int s = 0; s < 8; s++)
            cycle(1, s[0], {3'b000, 3'(s), 26'h2AA_AAAB}, 4'(s + 5), 0, 0, 0, "R2 sweep");
        // Mixed random traffic with occasional reconfiguration.
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            cycle(rb[0] | rb[1], rb[2], ra, rb[7:4], rb[11:8] == 4'd0,
                  rb[14:12], rb[17:15], "random");
        end
        idle("final idle");
        finish_run();
    end

endmodule